// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Controller

This block keeps the status byte of a serial EEPROM whose array spans a 13-bit address space, and it judges every write attempt against that byte. The command decoder in front of it hands over one-cycle strobes for write-enable, write-disable and status-write, the last with its data byte. The array path presents a write request with a target address. The block also watches the active-low write-protect pin and a busy flag from the internal write engine.

For each request it answers one clock later with a one-cycle grant pulse or a one-cycle deny pulse. A grant for an array write or a status write arms the write-enable latch for automatic clearing. The latch clears at the end of the following busy period. The two range-select bits and the hardware-lock enable stand in for non-volatile cells. They are plain registers that load from an initial-value input during reset.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: The status byte reads, from bit 7 down, lock-enable, three zero bits, range select high, range select low, write-enable latch, busy. Bits 6 to 4 always read 0. In a status-write data byte only bit 7 (lock-enable) and bits 3:2 (range select) are taken; the other bits are ignored.
- R2: Status bit 0 equals the busy input in the same cycle.
- R3: A write-enable strobe sets the latch (bit 1) and a write-disable strobe clears it. When both arrive in the same cycle, the clear wins.
- R4: Range select 2'b00 protects no address. 2'b01 protects 0x1800 to 0x1FFF. 2'b10 protects 0x1000 to 0x1FFF. 2'b11 protects the whole array.
- R5: Range select and lock-enable change only through a granted status write. A denied status write leaves them as they were.
- R6: An array write to a protected address is denied, whatever the latch, the lock-enable bit and the pin.
- R7: An array write to an unprotected address is granted exactly when the latch is 1, whether or not hardware locking is active.
- R8: A status write is granted only when the latch is 1 and hardware locking is off. Hardware locking is on when lock-enable is 1 and the pin is low.
- R9: After a granted write, the latch clears in the cycle after the busy input falls. A denied request leaves the latch unchanged.
- R10: While busy is 1, every array and status write is denied, and the enable and disable strobes leave the latch unchanged.
- R11: Each request produces exactly one of grant or deny, as a single-cycle pulse in the cycle after the request.
- R12: When an array write and a status write arrive in the same cycle, the status write is denied and the array write is judged alone.
- R13: Reset clears the latch and loads range select and lock-enable from the initial-value inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_blk_i | input | 2 | Range select loaded during reset |
| init_lock_en_i | input | 1 | Lock-enable value loaded during reset |
| cmd_wren_i | input | 1 | Write-enable strobe |
| cmd_wrdi_i | input | 1 | Write-disable strobe |
| cmd_wrsr_i | input | 1 | Status-write request |
| wrsr_data_i | input | 8 | Status-write data byte |
| mem_wr_req_i | input | 1 | Array write request |
| mem_wr_addr_i | input | 13 | Array write address |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal write engine busy |
| status_o | output | 8 | Status byte |
| mem_grant_o | output | 1 | Array write granted pulse |
| mem_deny_o | output | 1 | Array write denied pulse |
| sr_grant_o | output | 1 | Status write granted pulse |
| sr_deny_o | output | 1 | Status write denied pulse |

## Verification
The bench probes the range edges 0x17FF/0x1800 and 0x0FFF/0x1000. A comparator that is off by one or decodes the wrong bits would grant a locked location or refuse a free one. It also writes the unprotected region while the pin is locking the status byte. A design that applied the pin to the array would deny those writes. It sends a status byte with every ignored bit set, which catches stray latch or zero-bit corruption, and it checks that the latch clears only after busy falls and stays set after a denial. Strobes and requests issued while busy, and a same-cycle array/status pair, expose a design that lets the wrong request through.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int SR_W        = 8;
  localparam int RDY_BIT     = 0;
  localparam int WEL_BIT     = 1;
  localparam int BLK_LO_BIT  = 2;
  localparam int BLK_HI_BIT  = 3;
  localparam int LOCK_EN_BIT = 7;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_sel_e;

  typedef struct packed {
    logic mem_grant;
    logic mem_deny;
    logic sr_grant;
    logic sr_deny;
  } resp_t;
endpackage

// File: rtl/wpc_rst_sync.sv
module wpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wpc_range_chk.sv
module wpc_range_chk
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  prot_sel_e         blk,
  output logic              hit
);
  logic top_quarter;
  logic top_half;

  assign top_quarter = &addr[ADDR_W-1 -: 2];
  assign top_half    = addr[ADDR_W-1];

  always_comb begin
    unique case (blk)
      PROT_NONE: hit = 1'b0;
      PROT_QTR:  hit = top_quarter;
      PROT_HALF: hit = top_half;
      PROT_ALL:  hit = 1'b1;
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpc_decide.sv
module wpc_decide
  import wpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mem_req,
  input  logic hit,
  input  logic sr_req,
  input  logic wel,
  input  logic lock_en,
  input  logic wp_n,
  input  logic busy,
  output logic mem_ok,
  output logic sr_ok,
  output logic mem_grant,
  output logic mem_deny,
  output logic sr_grant,
  output logic sr_deny
);
  logic  hw_lock;
  logic  idle;
  resp_t resp_d;
  resp_t resp_q;

  assign hw_lock = lock_en & ~wp_n;
  assign idle    = ~busy;

  always_comb begin
    mem_ok           = mem_req & idle & wel & ~hit;
    sr_ok            = sr_req & ~mem_req & idle & wel & ~hw_lock;
    resp_d.mem_grant = mem_ok;
    resp_d.mem_deny  = mem_req & ~mem_ok;
    resp_d.sr_grant  = sr_ok;
    resp_d.sr_deny   = sr_req & ~sr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end

  assign mem_grant = resp_q.mem_grant;
  assign mem_deny  = resp_q.mem_deny;
  assign sr_grant  = resp_q.sr_grant;
  assign sr_deny   = resp_q.sr_deny;
endmodule

// File: rtl/wpc_status.sv
module wpc_status
  import wpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  prot_sel_e       init_blk,
  input  logic            init_lock_en,
  input  logic            wren,
  input  logic            wrdi,
  input  logic            sr_load,
  input  logic [SR_W-1:0] sr_data,
  input  logic            start,
  input  logic            busy,
  output logic            wel,
  output prot_sel_e       blk,
  output logic            lock_en
);
  logic      wel_q, wel_d;
  logic      pend_q, pend_d;
  logic      busy_q;
  logic      busy_fall;
  prot_sel_e blk_q, blk_d;
  logic      lock_q, lock_d;
  logic      wel_en;

  assign busy_fall = busy_q & ~busy;
  assign wel_en    = ~busy;

  always_comb begin
    wel_d = wel_q;
    if (pend_q && busy_fall) wel_d = 1'b0;
    else if (wrdi)           wel_d = 1'b0;
    else if (wren)           wel_d = 1'b1;

    pend_d = pend_q;
    if (start)          pend_d = 1'b1;
    else if (busy_fall) pend_d = 1'b0;

    blk_d  = blk_q;
    lock_d = lock_q;
    if (sr_load) begin
      blk_d  = prot_sel_e'(sr_data[BLK_HI_BIT:BLK_LO_BIT]);
      lock_d = sr_data[LOCK_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      blk_q  <= init_blk;
      lock_q <= init_lock_en;
    end else begin
      busy_q <= busy;
      pend_q <= pend_d;
      if (wel_en)  wel_q  <= wel_d;
      if (sr_load) blk_q  <= blk_d;
      if (sr_load) lock_q <= lock_d;
    end
  end

  assign wel     = wel_q;
  assign blk     = blk_q;
  assign lock_en = lock_q;
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        init_blk_i,
  input  logic              init_lock_en_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              mem_wr_req_i,
  input  logic [ADDR_W-1:0] mem_wr_addr_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  output logic [7:0]        status_o,
  output logic              mem_grant_o,
  output logic              mem_deny_o,
  output logic              sr_grant_o,
  output logic              sr_deny_o
);
  logic      rst_sync_n;
  logic      hit;
  logic      mem_ok;
  logic      sr_ok;
  logic      wel;
  logic      lock_en;
  prot_sel_e blk;

  wpc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  wpc_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .addr(mem_wr_addr_i),
    .blk (blk),
    .hit (hit)
  );

  wpc_decide u_decide (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mem_req  (mem_wr_req_i),
    .hit      (hit),
    .sr_req   (cmd_wrsr_i),
    .wel      (wel),
    .lock_en  (lock_en),
    .wp_n     (wp_n_i),
    .busy     (busy_i),
    .mem_ok   (mem_ok),
    .sr_ok    (sr_ok),
    .mem_grant(mem_grant_o),
    .mem_deny (mem_deny_o),
    .sr_grant (sr_grant_o),
    .sr_deny  (sr_deny_o)
  );

  wpc_status u_status (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .init_blk    (prot_sel_e'(init_blk_i)),
    .init_lock_en(init_lock_en_i),
    .wren        (cmd_wren_i),
    .wrdi        (cmd_wrdi_i),
    .sr_load     (sr_ok),
    .sr_data     (wrsr_data_i),
    .start       (mem_ok | sr_ok),
    .busy        (busy_i),
    .wel         (wel),
    .blk         (blk),
    .lock_en     (lock_en)
  );

  always_comb begin
    status_o                          = '0;
    status_o[LOCK_EN_BIT]             = lock_en;
    status_o[BLK_HI_BIT:BLK_LO_BIT]   = blk;
    status_o[WEL_BIT]                 = wel;
    status_o[RDY_BIT]                 = busy_i;
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wrsr_i,
  input logic              mem_wr_req_i,
  input logic [ADDR_W-1:0] mem_wr_addr_i,
  input logic              wp_n_i,
  input logic              busy_i,
  input logic [7:0]        status_o,
  input logic              mem_grant_o,
  input logic              mem_deny_o,
  input logic              sr_grant_o,
  input logic              sr_deny_o
);
  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

  assert_rdy_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] == busy_i);

  assert_cfg_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wrsr_i |=> $stable({status_o[7], status_o[3:2]}));

  assert_full_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_o |-> $past(status_o[3:2]) != 2'b11);

  assert_grant_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_o |-> $past(status_o[1]));

  assert_sr_hw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_o |-> $past(status_o[1] && !(status_o[7] && !wp_n_i)));

  assert_busy_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_grant_o || sr_grant_o) |-> !$past(busy_i));

  assert_wel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(status_o[1]));

  assert_mem_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_grant_o && mem_deny_o) && !(sr_grant_o && sr_deny_o));

  assert_mem_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_grant_o || mem_deny_o) |-> $past(mem_wr_req_i));

  assert_sr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant_o || sr_deny_o) |-> $past(cmd_wrsr_i));

  assert_pair_sr_denied_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_o |-> !$past(mem_wr_req_i));
endmodule

bind eeprom_wp_ctrl wpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_wrsr_i   (cmd_wrsr_i),
  .mem_wr_req_i (mem_wr_req_i),
  .mem_wr_addr_i(mem_wr_addr_i),
  .wp_n_i       (wp_n_i),
  .busy_i       (busy_i),
  .status_o     (status_o),
  .mem_grant_o  (mem_grant_o),
  .mem_deny_o   (mem_deny_o),
  .sr_grant_o   (sr_grant_o),
  .sr_deny_o    (sr_deny_o)
);

// File: tb/sim_eeprom_wp_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_wp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  init_blk;
  logic        init_lock_en;
  logic        cmd_wren, cmd_wrdi, cmd_wrsr;
  logic [7:0]  wrsr_data;
  logic        mem_req;
  logic [12:0] mem_addr;
  logic        wp_n;
  logic        busy;
  logic [7:0]  status;
  logic        mem_grant, mem_deny, sr_grant, sr_deny;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  eeprom_wp_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .init_blk_i(init_blk), .init_lock_en_i(init_lock_en),
    .cmd_wren_i(cmd_wren), .cmd_wrdi_i(cmd_wrdi), .cmd_wrsr_i(cmd_wrsr),
    .wrsr_data_i(wrsr_data), .mem_wr_req_i(mem_req), .mem_wr_addr_i(mem_addr),
    .wp_n_i(wp_n), .busy_i(busy), .status_o(status),
    .mem_grant_o(mem_grant), .mem_deny_o(mem_deny),
    .sr_grant_o(sr_grant), .sr_deny_o(sr_deny)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_wren();
    @(negedge clk) cmd_wren = 1'b1;
    @(negedge clk) cmd_wren = 1'b0;
  endtask

  task automatic do_wrdi();
    @(negedge clk) cmd_wrdi = 1'b1;
    @(negedge clk) cmd_wrdi = 1'b0;
  endtask

  task automatic run_engine();
    busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic mem_write(logic [12:0] a, bit exp_grant, string req);
    @(negedge clk);
    mem_req = 1'b1; mem_addr = a;
    @(negedge clk);
    mem_req = 1'b0;
    chk({req, " R11 array response"}, {mem_grant, mem_deny}, exp_grant ? 8'h2 : 8'h1);
    if (exp_grant && !busy) run_engine();
    else @(negedge clk);
    chk("R11 array pulse one clock", {mem_grant, mem_deny}, 8'h0);
  endtask

  task automatic sr_write(logic [7:0] d, bit exp_grant, string req);
    @(negedge clk);
    cmd_wrsr = 1'b1; wrsr_data = d;
    @(negedge clk);
    cmd_wrsr = 1'b0;
    chk({req, " R11 status response"}, {sr_grant, sr_deny}, exp_grant ? 8'h2 : 8'h1);
    if (exp_grant && !busy) run_engine();
    else @(negedge clk);
    chk("R11 status pulse one clock", {sr_grant, sr_deny}, 8'h0);
  endtask

  task automatic t_reset();
    init_blk = 2'b01; init_lock_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 reset status", status, 8'h84);
    chk("R11 no pulse after reset", {mem_grant, mem_deny, sr_grant, sr_deny}, 8'h0);
  endtask

  task automatic t_latch_cmds();
    do_wren();
    chk("R3 enable sets latch", status, 8'h86);
    do_wrdi();
    chk("R3 disable clears latch", status, 8'h84);
    do_wren();
    @(negedge clk) begin cmd_wren = 1'b1; cmd_wrdi = 1'b1; end
    @(negedge clk) begin cmd_wren = 1'b0; cmd_wrdi = 1'b0; end
    chk("R3 disable wins", status, 8'h84);
  endtask

  task automatic t_quarter();
    wp_n = 1'b0;
    mem_write(13'h0000, 1'b0, "R7 latch clear denies");
    do_wren();
    mem_write(13'h17FF, 1'b1, "R4 R7 below quarter under hw lock");
    chk("R9 latch cleared after busy", status, 8'h84);
    do_wren();
    mem_write(13'h1800, 1'b0, "R6 quarter start");
    chk("R9 deny keeps latch", status, 8'h86);
    mem_write(13'h1FFF, 1'b0, "R6 quarter end");
  endtask

  task automatic t_sr_lock();
    sr_write(8'h00, 1'b0, "R8 hw lock");
    chk("R5 denied status write keeps cfg", status, 8'h86);
    wp_n = 1'b1;
    sr_write(8'h7B, 1'b1, "R8 pin high");
    chk("R1 ignored data bits", status, 8'h08);
  endtask

  task automatic t_half();
    do_wren();
    mem_write(13'h0FFF, 1'b1, "R4 below half");
    do_wren();
    mem_write(13'h1000, 1'b0, "R6 half start");
    wp_n = 1'b0;
    sr_write(8'h8C, 1'b1, "R8 lock-enable off, pin low");
    chk("R5 cfg loaded", status, 8'h8C);
  endtask

  task automatic t_full();
    do_wren();
    mem_write(13'h0000, 1'b0, "R4 R6 full");
    sr_write(8'h00, 1'b0, "R8 hw lock again");
    wp_n = 1'b1;
    sr_write(8'h00, 1'b1, "R8 unlock");
    chk("R5 cfg cleared", status, 8'h00);
    do_wren();
    mem_write(13'h1FFF, 1'b1, "R4 none protects nothing");
  endtask

  task automatic t_busy();
    do_wren();
    @(negedge clk) busy = 1'b1;
    @(negedge clk);
    chk("R2 busy bit", status, 8'h03);
    do_wrdi();
    chk("R10 disable ignored when busy", status, 8'h03);
    mem_write(13'h0010, 1'b0, "R10 array busy");
    sr_write(8'h00, 1'b0, "R10 status busy");
    busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 latch kept without grant", status, 8'h02);
  endtask

  task automatic t_pair();
    @(negedge clk);
    mem_req = 1'b1; mem_addr = 13'h0100;
    cmd_wrsr = 1'b1; wrsr_data = 8'h8C;
    @(negedge clk);
    mem_req = 1'b0; cmd_wrsr = 1'b0;
    chk("R12 array granted", {mem_grant, mem_deny}, 8'h2);
    chk("R12 status denied", {sr_grant, sr_deny}, 8'h1);
    run_engine();
    chk("R12 cfg untouched, R9 latch cleared", status, 8'h00);
  endtask

  initial begin
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wrsr_data = 0;
    mem_req = 0; mem_addr = 0; wp_n = 1; busy = 0;
    init_blk = 0; init_lock_en = 0; rst_n = 0;
    t_reset();
    t_latch_cmds();
    t_quarter();
    t_sr_lock();
    t_half();
    t_full();
    t_busy();
    t_pair();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule